// File: doc/BRIEF.md
# Shared ROM/SRAM Bus Controller

This block owns one external asynchronous memory bus on which a 16-bit ROM and an SRAM sit side by side, with common address and data lines. Two internal clients share it: a signal-processing engine and a control processor. Each client raises a level request with a 25-bit word address, a direction and a target (ROM or RAM). The request stays up until the block answers with a one-cycle done pulse, and read data is presented in the same cycle as that pulse. When both clients are waiting, the signal-processing engine goes first.

Every access occupies a fixed five-cycle word slot of the 38.4 MHz core clock, about 130 ns. Chip select and address are presented first, and output enable or write enable follows two cycles later. The SRAM may be 16 bits wide or 8 bits wide. In the 8-bit case, each word is moved as two byte transfers on data lines [7:0] inside the same five-cycle slot. A byte-select line acts as the lowest RAM address bit and steps from the low byte to the high byte. The data bus leaves the block as an output value, an output-enable flag and an input value, so that the pad ring can build the tri-state buffer.

Top module: `shared_mem_ctrl`

## Requirements
- R1: Between accesses, rom_cs_n, ram_cs_n, oe_n and we_n are all 1, bsel is 0 and dq_oe is 0. This is also the state after reset.
- R2: A ROM read (target input 0, write input 0) holds rom_cs_n low for 5 consecutive cycles. oe_n goes low in the 3rd of those cycles and stays low to the 5th. rd_data becomes the full 16-bit dq_i value seen in the 5th cycle.
- R3: A RAM write (target input 1, write input 1) in 16-bit mode (narrow_ram=0) holds ram_cs_n low for 5 cycles. we_n is low in cycles 3 to 5 and oe_n stays high. dq_oe is 1 exactly while we_n is low, and dq_o carries the write word during that time.
- R4: A RAM read with narrow_ram=1 keeps oe_n low in cycles 3 to 5. bsel is 0 up to the 4th cycle and 1 in the 5th. dq_i[7:0] from the 4th cycle becomes rd_data[7:0], and dq_i[7:0] from the 5th cycle becomes rd_data[15:8]. dq_i[15:8] is ignored.
- R5: A RAM write with narrow_ram=1 gives two one-cycle we_n pulses, in cycles 3 and 5. The first pulse carries the low byte on dq_o[7:0] with bsel=0. bsel rises in cycle 4, and the second pulse carries the high byte. dq_o[15:8] is 0 during both pulses.
- R6: A write aimed at the ROM asserts no chip select, no we_n and no oe_n. It still occupies the 5-cycle slot and still returns a done pulse.
- R7: When both clients request in the same cycle, the signal-processing client (dsp_*) is served first. The control client is served in the next slot.
- R8: The done pulse of the served client is high for exactly one cycle, in the cycle right after the 5th access cycle. mem_addr equals the request address throughout the access.
- R9: ROM reads ignore narrow_ram. They use all 16 data lines and keep bsel at 0.
- R10: oe_n and we_n are never low together, and rom_cs_n and ram_cs_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| narrow_ram | input | 1 | 1: SRAM is 8 bits wide, 0: 16 bits wide |
| dsp_req | input | 1 | Signal-processing client request, held until done |
| dsp_we | input | 1 | 1 = write, 0 = read |
| dsp_ram | input | 1 | 1 = RAM target, 0 = ROM target |
| dsp_addr | input | 25 | Word address |
| dsp_wdata | input | 16 | Write word |
| dsp_done | output | 1 | One-cycle completion pulse |
| cpu_req | input | 1 | Control client request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_ram | input | 1 | 1 = RAM target, 0 = ROM target |
| cpu_addr | input | 25 | Word address |
| cpu_wdata | input | 16 | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read word, valid with the done pulse |
| mem_addr | output | 25 | External word address |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| bsel | output | 1 | Byte select for an 8-bit SRAM (0 low byte, 1 high byte) |
| dq_o | output | 16 | Data bus value driven out |
| dq_oe | output | 1 | Data bus drive enable |
| dq_i | input | 16 | Data bus value read in |

## Verification
A request raised before clock edge k is granted at edge k. The strobes for access cycle j (j = 1 to 5) are visible after edge k+j-1. The done pulse and rd_data appear after edge k+5, so a new slot can start no earlier than edge k+7. The bench runs a behavioural phase model that advances on every rising edge from the same request inputs, and it compares every pin on the following falling edge. Each check therefore lands in the cycle where the requirement says the value is due. A bench-side memory answers dq_i from the live strobes and records writes, so the read-back values test the byte ordering end to end.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic rom_cs_n;
        logic ram_cs_n;
        logic oe_n;
        logic we_n;
        logic bsel;
        logic drive;
    } pin_t;

    localparam pin_t PINS_IDLE = '{rom_cs_n: 1'b1, ram_cs_n: 1'b1, oe_n: 1'b1,
                                   we_n: 1'b1, bsel: 1'b0, drive: 1'b0};

    // Strobe pattern for one cycle of the word slot.
    function automatic pin_t pin_decode(input logic active, input int ph,
                                        input int lead, input int last,
                                        input logic wr, input logic to_ram,
                                        input logic narrow);
        pin_t p;
        p = PINS_IDLE;
        if (active) begin
            if (to_ram) begin
                p.ram_cs_n = 1'b0;
            end else if (!wr) begin
                p.rom_cs_n = 1'b0;
            end
            if (!wr) begin
                p.oe_n = !(ph >= lead);
                if (to_ram && narrow) begin
                    p.bsel = (ph == last);
                end
            end else if (to_ram) begin
                if (narrow) begin
                    p.we_n = !((ph == lead) || (ph == last));
                    p.bsel = (ph > lead);
                end else begin
                    p.we_n = !(ph >= lead);
                end
                p.drive = !p.we_n;
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/smc_prio_arb.sv
module smc_prio_arb #(
    parameter int NREQ = 2
) (
    input  logic            en,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gnt
);
    logic [NREQ-1:0] blocked;

    assign blocked[0] = 1'b0;
    for (genvar i = 1; i < NREQ; i++) begin : g_chain
        assign blocked[i] = blocked[i-1] | req[i-1];
    end

    assign gnt = en ? (req & ~blocked) : '0;
endmodule

// File: rtl/smc_seq.sv
module smc_seq
    import smc_pkg::*;
#(
    parameter int NREQ      = 2,
    parameter int AW        = 25,
    parameter int DW        = 16,
    parameter int CYC_TOTAL = 5,
    parameter int LEAD      = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     narrow_mode,
    input  logic [NREQ-1:0]          gnt,
    input  logic [NREQ-1:0]          req_we,
    input  logic [NREQ-1:0]          req_ram,
    input  logic [NREQ-1:0][AW-1:0]  req_addr,
    input  logic [NREQ-1:0][DW-1:0]  req_wdata,
    input  logic [DW-1:0]            dq_i,
    output logic                     idle_o,
    output logic [NREQ-1:0]          done_o,
    output logic [DW-1:0]            rdata_o,
    output logic [AW-1:0]            addr_o,
    output pin_t                     pins_o,
    output logic [DW-1:0]            dq_o
);
    localparam int CNT_W = $clog2(CYC_TOTAL);
    localparam int WHO_W = (NREQ > 1) ? $clog2(NREQ) : 1;
    localparam int HALF  = DW / 2;
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CYC_TOTAL - 1);
    localparam logic [CNT_W-1:0] LOWCAP_C = CNT_W'(CYC_TOTAL - 2);
    localparam logic [CNT_W-1:0] LEAD_C = CNT_W'(LEAD);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic [WHO_W-1:0] who;
        logic             wr;
        logic             ram;
        logic             narrow;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
        logic [DW-1:0]    dq;
        pin_t             pins;
        logic [NREQ-1:0]  done;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = '0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (|gnt) begin
                    seq_d.st     = SEQ_RUN;
                    seq_d.cnt    = '0;
                    seq_d.narrow = narrow_mode;
                    for (int i = 0; i < NREQ; i++) begin
                        if (gnt[i]) begin
                            seq_d.who   = WHO_W'(i);
                            seq_d.wr    = req_we[i];
                            seq_d.ram   = req_ram[i];
                            seq_d.addr  = req_addr[i];
                            seq_d.wdata = req_wdata[i];
                        end
                    end
                end
            end
            SEQ_RUN: begin
                if (!seq_q.wr) begin
                    if (seq_q.narrow && seq_q.ram) begin
                        if (seq_q.cnt == LOWCAP_C) begin
                            seq_d.rdata[HALF-1:0] = dq_i[HALF-1:0];
                        end
                        if (seq_q.cnt == LAST_C) begin
                            seq_d.rdata[DW-1:HALF] = dq_i[HALF-1:0];
                        end
                    end else if (seq_q.cnt == LAST_C) begin
                        seq_d.rdata = dq_i;
                    end
                end
                if (seq_q.cnt == LAST_C) begin
                    seq_d.st             = SEQ_DONE;
                    seq_d.done[seq_q.who] = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_DONE: seq_d.st = SEQ_IDLE;
            default:  seq_d.st = SEQ_IDLE;
        endcase

        seq_d.pins = pin_decode(seq_d.st == SEQ_RUN, int'(seq_d.cnt), LEAD,
                                CYC_TOTAL - 1, seq_d.wr, seq_d.ram, seq_d.narrow);
        seq_d.dq = '0;
        if (seq_d.pins.drive) begin
            if (!seq_d.narrow) begin
                seq_d.dq = seq_d.wdata;
            end else if (seq_d.cnt > LEAD_C) begin
                seq_d.dq = {{HALF{1'b0}}, seq_d.wdata[DW-1:HALF]};
            end else begin
                seq_d.dq = {{HALF{1'b0}}, seq_d.wdata[HALF-1:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.pins <= PINS_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idle_o  = (seq_q.st == SEQ_IDLE);
    assign done_o  = seq_q.done;
    assign rdata_o = seq_q.rdata;
    assign addr_o  = seq_q.addr;
    assign pins_o  = seq_q.pins;
    assign dq_o    = seq_q.dq;

    // R10
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!seq_q.pins.oe_n && !seq_q.pins.we_n));
    // R10
    cs_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!seq_q.pins.rom_cs_n && !seq_q.pins.ram_cs_n));
    // R6
    we_ram_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.pins.we_n |-> !seq_q.pins.ram_cs_n);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|seq_q.done) |=> !(|seq_q.done));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seq_q.done));
    // R2
    oe_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.pins.oe_n) |-> $past(!seq_q.pins.rom_cs_n || !seq_q.pins.ram_cs_n));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.pins.rom_cs_n && seq_q.pins.ram_cs_n) |-> (!seq_q.pins.bsel && !seq_q.pins.drive));
    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!seq_q.pins.rom_cs_n || !seq_q.pins.ram_cs_n) &&
         $past(!seq_q.pins.rom_cs_n || !seq_q.pins.ram_cs_n)) |-> $stable(seq_q.addr));
endmodule

// File: rtl/shared_mem_ctrl.sv
module shared_mem_ctrl
    import smc_pkg::*;
#(
    parameter int AW        = 25,
    parameter int DW        = 16,
    parameter int CYC_TOTAL = 5,
    parameter int LEAD      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          narrow_ram,
    input  logic          dsp_req,
    input  logic          dsp_we,
    input  logic          dsp_ram,
    input  logic [AW-1:0] dsp_addr,
    input  logic [DW-1:0] dsp_wdata,
    output logic          dsp_done,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic          cpu_ram,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          rom_cs_n,
    output logic          ram_cs_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          bsel,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    input  logic [DW-1:0] dq_i
);
    localparam int NREQ = 2;

    logic [NREQ-1:0]         req_v, gnt_v, done_v;
    logic [NREQ-1:0]         we_v, ram_v;
    logic [NREQ-1:0][AW-1:0] addr_v;
    logic [NREQ-1:0][DW-1:0] wdata_v;
    logic                    seq_idle;
    pin_t                    pins;

    assign req_v   = {cpu_req, dsp_req};
    assign we_v    = {cpu_we, dsp_we};
    assign ram_v   = {cpu_ram, dsp_ram};
    assign addr_v  = {cpu_addr, dsp_addr};
    assign wdata_v = {cpu_wdata, dsp_wdata};

    smc_prio_arb #(.NREQ(NREQ)) arb_i (
        .en  (seq_idle),
        .req (req_v),
        .gnt (gnt_v)
    );

    smc_seq #(
        .NREQ(NREQ), .AW(AW), .DW(DW), .CYC_TOTAL(CYC_TOTAL), .LEAD(LEAD)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .narrow_mode (narrow_ram),
        .gnt         (gnt_v),
        .req_we      (we_v),
        .req_ram     (ram_v),
        .req_addr    (addr_v),
        .req_wdata   (wdata_v),
        .dq_i        (dq_i),
        .idle_o      (seq_idle),
        .done_o      (done_v),
        .rdata_o     (rd_data),
        .addr_o      (mem_addr),
        .pins_o      (pins),
        .dq_o        (dq_o)
    );

    assign dsp_done = done_v[0];
    assign cpu_done = done_v[1];
    assign rom_cs_n = pins.rom_cs_n;
    assign ram_cs_n = pins.ram_cs_n;
    assign oe_n     = pins.oe_n;
    assign we_n     = pins.we_n;
    assign bsel     = pins.bsel;
    assign dq_oe    = pins.drive;
endmodule

// File: tb/shared_mem_ctrl_tb_top.sv
module shared_mem_ctrl_tb_top;
    localparam int CLK_PERIOD = 26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        narrow_ram = 1'b0;
    logic        dsp_req = 1'b0, dsp_we = 1'b0, dsp_ram = 1'b0;
    logic [24:0] dsp_addr = '0;
    logic [15:0] dsp_wdata = '0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_ram = 1'b0;
    logic [24:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        dsp_done, cpu_done;
    logic [15:0] rd_data;
    logic [24:0] mem_addr;
    logic        rom_cs_n, ram_cs_n, oe_n, we_n, bsel, dq_oe;
    logic [15:0] dq_o;
    logic [15:0] dq_i;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_mem_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .narrow_ram(narrow_ram),
        .dsp_req(dsp_req), .dsp_we(dsp_we), .dsp_ram(dsp_ram),
        .dsp_addr(dsp_addr), .dsp_wdata(dsp_wdata), .dsp_done(dsp_done),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ram(cpu_ram),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .rd_data(rd_data), .mem_addr(mem_addr), .rom_cs_n(rom_cs_n),
        .ram_cs_n(ram_cs_n), .oe_n(oe_n), .we_n(we_n), .bsel(bsel),
        .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
    );

    // ---------------- external memories ----------------
    logic [15:0] ram16 [256];
    logic [7:0]  ram8  [512];

    function automatic logic [15:0] rom_word(input logic [24:0] a);
        return {a[7:0], ~a[15:8]} ^ {7'h0, a[24:16]};
    endfunction

    always_comb begin
        dq_i = 16'hDEAD;
        if (!oe_n) begin
            if (!rom_cs_n) dq_i = rom_word(mem_addr);
            else if (!ram_cs_n) dq_i = narrow_ram ? {8'hEE, ram8[{mem_addr[7:0], bsel}]}
                                                  : ram16[mem_addr[7:0]];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          ph = -1;   // -1 idle, 0..4 slot cycle, 5 done cycle
    int          who = 0;
    bit          m_we, m_ram, m_nar;
    logic [24:0] m_addr;
    logic [15:0] m_wd, m_rd;

    function automatic logic [15:0] mem_view(input bit r, input bit nar, input logic [24:0] a);
        if (!r) return rom_word(a);
        if (nar) return {ram8[{a[7:0], 1'b1}], ram8[{a[7:0], 1'b0}]};
        return ram16[a[7:0]];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = -1;
        end else if (ph == -1) begin
            if (dsp_req) begin
                who = 0; m_we = dsp_we; m_ram = dsp_ram; m_addr = dsp_addr; m_wd = dsp_wdata;
                m_nar = narrow_ram; ph = 0;
                m_rd = mem_view(m_ram, m_nar, m_addr);
            end else if (cpu_req) begin
                who = 1; m_we = cpu_we; m_ram = cpu_ram; m_addr = cpu_addr; m_wd = cpu_wdata;
                m_nar = narrow_ram; ph = 0;
                m_rd = mem_view(m_ram, m_nar, m_addr);
            end
        end else if (ph < 5) begin
            ph = ph + 1;
        end else begin
            ph = -1;
        end
    end

    // per-cycle comparison and memory write capture
    always @(negedge clk) begin
        if (running) begin
            bit run;
            bit e_rom, e_ramcs, e_oe, e_we, e_bsel;
            logic [15:0] e_dq;
            run     = (ph >= 0) && (ph <= 4);
            e_rom   = !(run && !m_ram && !m_we);
            e_ramcs = !(run && m_ram);
            e_oe    = !(run && !m_we && ph >= 2);
            e_we    = !(run && m_we && m_ram && (m_nar ? (ph == 2 || ph == 4) : ph >= 2));
            e_bsel  = run && m_ram && m_nar && (m_we ? (ph >= 3) : (ph == 4));
            e_dq    = m_nar ? {8'h00, (ph >= 3) ? m_wd[15:8] : m_wd[7:0]} : m_wd;
            check("R1/R2/R6 rom_cs_n", 32'(rom_cs_n), 32'(e_rom));
            check("R1/R3/R4 ram_cs_n", 32'(ram_cs_n), 32'(e_ramcs));
            check("R2/R4/R9 oe_n", 32'(oe_n), 32'(e_oe));
            check("R3/R5/R6 we_n", 32'(we_n), 32'(e_we));
            check("R4/R5/R9 bsel", 32'(bsel), 32'(e_bsel));
            check("R1/R3 dq_oe", 32'(dq_oe), 32'(!e_we));
            if (!e_we) check("R3/R5 dq_o", 32'(dq_o), 32'(e_dq));
            if (run) check("R8 mem_addr", 32'(mem_addr), 32'(m_addr));
            check("R8 dsp_done", 32'(dsp_done), 32'(ph == 5 && who == 0));
            check("R8 cpu_done", 32'(cpu_done), 32'(ph == 5 && who == 1));
            if (ph == 5 && !m_we) check("R2/R4/R9 rd_data", 32'(rd_data), 32'(m_rd));
            check("R10 oe/we exclusive", 32'(!oe_n && !we_n), 32'(0));
            check("R10 cs exclusive", 32'(!rom_cs_n && !ram_cs_n), 32'(0));
        end
        if (!we_n && !ram_cs_n) begin
            if (narrow_ram) ram8[{mem_addr[7:0], bsel}] = dq_o[7:0];
            else ram16[mem_addr[7:0]] = dq_o;
        end
    end

    // ---------------- stimulus ----------------
    logic [15:0] got_d, got_c;
    int          ord_d, ord_c;

    task automatic go(input bit d, input bit c);
        int t;
        @(negedge clk);
        dsp_req = d; cpu_req = c;
        ord_d = -1; ord_c = -1; t = 0;
        while ((dsp_req || cpu_req) && t < 100) begin
            @(negedge clk);
            t++;
            if (dsp_done) begin dsp_req = 1'b0; got_d = rd_data; ord_d = t; end
            if (cpu_done) begin cpu_req = 1'b0; got_c = rd_data; ord_c = t; end
        end
        if (t >= 100) check("R8 done never arrived", 32'(1), 32'(0));
    endtask

    task automatic set_dsp(input bit w, input bit r, input logic [24:0] a, input logic [15:0] wd);
        dsp_we = w; dsp_ram = r; dsp_addr = a; dsp_wdata = wd;
    endtask

    task automatic set_cpu(input bit w, input bit r, input logic [24:0] a, input logic [15:0] wd);
        cpu_we = w; cpu_ram = r; cpu_addr = a; cpu_wdata = wd;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ram16[i] = 16'(i * 16'h0101 ^ 16'h3C00);
        for (int i = 0; i < 512; i++) ram8[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        running = 1'b1;
        check("R1 reset rom_cs_n", 32'(rom_cs_n), 32'(1));
        check("R1 reset dq_oe", 32'(dq_oe), 32'(0));
        rst_n = 1'b1;

        // R2 ROM reads from both clients
        set_dsp(1'b0, 1'b0, 25'h1ABCDE, 16'h0); go(1'b1, 1'b0);
        check("R2 dsp rom read", 32'(got_d), 32'(rom_word(25'h1ABCDE)));
        set_cpu(1'b0, 1'b0, 25'h0004F1, 16'h0); go(1'b0, 1'b1);
        check("R2 cpu rom read", 32'(got_c), 32'(rom_word(25'h0004F1)));

        // R3 16-bit RAM write then read back
        set_cpu(1'b1, 1'b1, 25'h000012, 16'hBEEF); go(1'b0, 1'b1);
        set_dsp(1'b0, 1'b1, 25'h000012, 16'h0); go(1'b1, 1'b0);
        check("R3 ram16 readback", 32'(got_d), 32'(16'hBEEF));

        // R6 write aimed at ROM: no strobes, done still given
        set_dsp(1'b1, 1'b0, 25'h000013, 16'h1234); go(1'b1, 1'b0);
        check("R6 rom write done", 32'(ord_d), 32'(6));
        set_dsp(1'b0, 1'b1, 25'h000013, 16'h0); go(1'b1, 1'b0);
        check("R6 ram untouched", 32'(got_d), 32'(16'h13 * 16'h0101 ^ 16'h3C00));

        // R7 simultaneous requests
        set_dsp(1'b0, 1'b1, 25'h000012, 16'h0);
        set_cpu(1'b0, 1'b0, 25'h000777, 16'h0);
        go(1'b1, 1'b1);
        check("R7 dsp first", 32'(ord_d < ord_c), 32'(1));
        check("R7 dsp data", 32'(got_d), 32'(16'hBEEF));
        check("R7 cpu data", 32'(got_c), 32'(rom_word(25'h000777)));

        // 8-bit SRAM mode
        @(negedge clk); narrow_ram = 1'b1;
        set_dsp(1'b0, 1'b1, 25'h000021, 16'h0); go(1'b1, 1'b0);
        check("R4 narrow read", 32'(got_d), 32'({ram8[9'h043], ram8[9'h042]}));
        set_cpu(1'b1, 1'b1, 25'h000034, 16'hA55A); go(1'b0, 1'b1);
        check("R5 low byte stored", 32'(ram8[9'h068]), 32'(8'h5A));
        check("R5 high byte stored", 32'(ram8[9'h069]), 32'(8'hA5));
        set_dsp(1'b0, 1'b1, 25'h000034, 16'h0); go(1'b1, 1'b0);
        check("R4/R5 narrow readback", 32'(got_d), 32'(16'hA55A));
        set_dsp(1'b0, 1'b0, 25'h0F0F0F, 16'h0); go(1'b1, 1'b0);
        check("R9 rom in narrow mode", 32'(got_d), 32'(rom_word(25'h0F0F0F)));

        // R7 simultaneous writes in narrow mode
        set_dsp(1'b1, 1'b1, 25'h000050, 16'h1357);
        set_cpu(1'b1, 1'b1, 25'h000050, 16'h2468);
        go(1'b1, 1'b1);
        check("R7 order writes", 32'(ord_d < ord_c), 32'(1));
        check("R7 last writer wins", 32'({ram8[9'h0A1], ram8[9'h0A0]}), 32'(16'h2468));

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule